// File: doc/BRIEF.md
# Degree-to-Phase Reducer with Sine Fold

This block sits in front of a rotation-based sine engine. It accepts an unsigned angle in whole degrees, including values far past one turn, and turns it into a phase word in which one full turn spans 2^18 codes. The modulo-360 step uses one multiplication by a fixed-point reciprocal of 360. Only the low 18 bits of the integer part of the product are kept. No divider and no subtraction loop are used.

The phase is then folded into the interval from -90 to +90 degrees without changing its sine. This is the input range the rotation engine accepts. Both the phase word and the signed folded angle are presented, with a valid flag, two clock cycles after a transfer is accepted on the input valid/ready handshake.

Top module: `angle_phase_fold`

## Requirements
- R1: For every accepted angle `a`, `out_phase` is within one code of (a mod 360) * 2^18 / 360, i.e. |out_phase*360 - (a mod 360)*2^18| < 360.
- R2: When (a mod 360) is a multiple of 45 degrees, `out_phase` and `out_angle` are exact, with no error code.
- R3: `out_angle` is a signed two's-complement word where a quarter turn is 2^16. It always lies in [-2^16, +2^16].
- R4: `out_angle` is the sine-preserving fold of the phase. Phase quadrant 0 (top two bits 00) passes unchanged. Quadrants 1 and 2 (01, 10) give half-turn minus phase. Quadrant 3 (11) gives phase minus full turn. It is negative exactly when the phase exceeds a half turn, and it is within one code of the folded degree value times 2^18/360.
- R5: Angles below 720 that differ by exactly 360 give identical `out_phase` and `out_angle`. For example, 390 gives the result of 30.
- R6: `out_valid` is high in exactly the cycles two clock edges after an edge at which `in_valid` and `in_ready` were both high.
- R7: `in_ready` is low while `arst_n` is low. It goes high within three clock edges after release and then stays high.
- R8: Cycles in which no transfer is accepted leave `out_phase` and `out_angle` unchanged, whatever `in_angle` carries.
- R9: While reset is held, `out_valid`, `out_phase` and `out_angle` are zero.
- R10: The largest input, 262143, reduces like any other angle: 63 degrees, phase within one code of 45875.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input angle is offered |
| in_ready | output | 1 | Block can take an angle |
| in_angle | input | 18 | Unsigned angle in degrees |
| out_valid | output | 1 | Results below are new this cycle |
| out_phase | output | 18 | Phase word, one turn = 2^18 |
| out_angle | output | 18 | Signed folded angle, quarter turn = 2^16 |

## Verification
A transfer accepted at a rising edge appears on `out_valid`, `out_phase` and `out_angle` just after the second rising edge that follows. The bench drives inputs on falling edges and checks outputs on later falling edges. It keeps a two-deep record of what it drove, so each check compares against the angle offered two falling edges earlier. Idle slots in that record are checked for a low `out_valid` and unchanged data. The readiness output is checked during reset and from the fourth falling edge after release.

// File: rtl/angle_fold_pkg.sv
package angle_fold_pkg;
  localparam int unsigned ANG_W_DEF  = 18;
  localparam int unsigned PH_W_DEF   = 18;
  localparam int unsigned FRAC_W_DEF = 16;

  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;
endpackage

// File: rtl/apf_rst_sync.sv
module apf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/apf_phase_mul.sv
module apf_phase_mul #(
  parameter int unsigned ANG_W  = 18,
  parameter int unsigned PH_W   = 18,
  parameter int unsigned FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ANG_W-1:0] angle_i,
  output logic [PH_W-1:0]  phase_o
);
  localparam int unsigned PW = PH_W + FRAC_W;
  // reciprocal of 360 rounded up, so the product never falls short
  localparam logic [PW-1:0] RECIP =
    PW'(((64'd1 << PW) + 64'd359) / 64'd360);

  logic [PH_W-1:0] phase_d;
  logic [PH_W-1:0] phase_q;

  always_comb begin
    phase_d = PH_W'((PW'(angle_i) * RECIP) >> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase_q <= '0;
    else if (en) phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/apf_fold.sv
module apf_fold
  import angle_fold_pkg::*;
#(
  parameter int unsigned PH_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [PH_W-1:0]        phase_i,
  output logic [PH_W-1:0]        phase_o,
  output logic signed [PH_W-1:0] fold_o
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);

  quad_e           quad;
  logic [PH_W-1:0] fold_d;
  logic [PH_W-1:0] fold_q;
  logic [PH_W-1:0] phase_q;

  always_comb begin
    quad = quad_e'(phase_i[PH_W-1 -: 2]);
    case (quad)
      QUAD_1, QUAD_2: fold_d = HALF - phase_i;
      default:        fold_d = phase_i;  // quadrant 3 wraps to phase - turn
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fold_q  <= '0;
      phase_q <= '0;
    end else if (en) begin
      fold_q  <= fold_d;
      phase_q <= phase_i;
    end
  end

  assign phase_o = phase_q;
  assign fold_o  = $signed(fold_q);
endmodule

// File: rtl/angle_phase_fold.sv
module angle_phase_fold
  import angle_fold_pkg::*;
#(
  parameter int unsigned ANG_W  = ANG_W_DEF,
  parameter int unsigned PH_W   = PH_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ANG_W-1:0]       in_angle,
  output logic                   out_valid,
  output logic [PH_W-1:0]        out_phase,
  output logic signed [PH_W-1:0] out_angle
);
  logic            rst_n;
  logic            rdy_q;
  logic            fire;
  logic            v1_q, v2_q;
  logic            v1_d, v2_d;
  logic [PH_W-1:0] ph1;

  apf_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign fire = in_valid & rdy_q;

  apf_phase_mul #(.ANG_W(ANG_W), .PH_W(PH_W), .FRAC_W(FRAC_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (fire),
    .angle_i (in_angle),
    .phase_o (ph1)
  );

  apf_fold #(.PH_W(PH_W)) u_fold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (v1_q),
    .phase_i (ph1),
    .phase_o (out_phase),
    .fold_o  (out_angle)
  );

  always_comb begin
    v1_d = fire;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      v1_q  <= v1_d;
      v2_q  <= v2_d;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = v2_q;
endmodule

// File: rtl/apf_checker.sv
module apf_checker #(
  parameter int unsigned PH_W = 18
) (
  input logic                   clk,
  input logic                   arst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic [PH_W-1:0]        out_phase,
  input logic signed [PH_W-1:0] out_angle
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);
  localparam int QT = 1 << (PH_W - 2);

  assert_fold_range_R3: assert property (@(posedge clk) disable iff (!arst_n)
    out_valid |-> (int'(out_angle) >= -QT && int'(out_angle) <= QT));

  assert_fold_sign_R4: assert property (@(posedge clk) disable iff (!arst_n)
    out_valid |-> ((out_angle < 0) == (out_phase > HALF)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && in_ready) |-> ##2 out_valid);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!arst_n)
    out_valid |-> $past(in_valid && in_ready, 2));

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!arst_n)
    in_ready |=> in_ready);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !out_valid |-> ($stable(out_phase) && $stable(out_angle)));
endmodule

bind angle_phase_fold apf_checker #(.PH_W(PH_W)) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_phase (out_phase),
  .out_angle (out_angle)
);

// File: tb/test_angle_phase_fold.sv
`timescale 1ns/1ps
module test_angle_phase_fold;
  logic               clk = 1'b0;
  logic               arst_n;
  logic               in_valid;
  logic               in_ready;
  logic [17:0]        in_angle;
  logic               out_valid;
  logic [17:0]        out_phase;
  logic signed [17:0] out_angle;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        hv0 = 1'b0, hv1 = 1'b0;
  logic [17:0] ha0 = '0,   ha1 = '0;
  longint      lp = 0, la = 0;
  longint      res_ph [0:359];
  longint      res_fd [0:359];

  always #2.5 clk = ~clk;

  angle_phase_fold i_angle_phase_fold (
    .clk       (clk),
    .arst_n    (arst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_angle  (in_angle),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .out_angle (out_angle)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out();
    longint r, fd, dp, df, ph, an;
    ph = longint'(out_phase);
    an = longint'(out_angle);
    if (hv1) begin
      r  = longint'(ha1) % 360;
      fd = (r < 90) ? r : ((r < 270) ? 180 - r : r - 360);
      dp = ph * 360 - r * 262144;
      df = an * 360 - fd * 262144;
      chk(out_valid === 1'b1, "R6 valid due", out_valid, 1);
      chk(dp > -360 && dp < 360, "R1 phase", ph, r * 262144 / 360);
      chk(df > -360 && df < 360, "R4 fold", an, fd * 262144 / 360);
      chk(an >= -65536 && an <= 65536, "R3 range", an, fd * 262144 / 360);
      if (r % 45 == 0) begin
        chk(dp == 0, "R2 exact phase", ph, r * 262144 / 360);
        chk(df == 0, "R2 exact fold", an, fd * 262144 / 360);
      end
      if (ha1 == 18'd262143) chk(dp > -360 && dp < 360, "R10 max input", ph, 45875);
      if (ha1 < 18'd360) begin
        res_ph[r] = ph;
        res_fd[r] = an;
      end else if (ha1 < 18'd720) begin
        chk(ph == res_ph[r], "R5 same phase", ph, res_ph[r]);
        chk(an == res_fd[r], "R5 same fold", an, res_fd[r]);
      end
      lp = ph;
      la = an;
    end else begin
      chk(out_valid === 1'b0, "R6 idle", out_valid, 0);
      chk(ph == lp, "R8 phase held", ph, lp);
      chk(an == la, "R8 fold held", an, la);
    end
  endtask

  task automatic step(input logic v, input logic [17:0] a);
    @(negedge clk);
    check_out();
    hv1 = hv0; ha1 = ha0;
    hv0 = v;   ha0 = a;
    in_valid = v;
    in_angle = a;
  endtask

  initial begin
    arst_n   = 1'b0;
    in_valid = 1'b0;
    in_angle = '0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b0, "R7 ready in reset", in_ready, 0);
    chk(out_valid === 1'b0, "R9 valid in reset", out_valid, 0);
    chk(out_phase === 18'd0, "R9 phase in reset", out_phase, 0);
    chk(out_angle === 18'sd0, "R9 fold in reset", out_angle, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b1, "R7 ready after release", in_ready, 1);

    for (int a = 0; a < 1440; a++) begin
      step(1'b1, 18'(a));
      if (a % 7 == 3) step(1'b0, 18'h3ffff);
    end
    step(1'b1, 18'd0);
    step(1'b1, 18'd90);
    step(1'b1, 18'd180);
    step(1'b1, 18'd270);
    step(1'b1, 18'd360);
    step(1'b1, 18'd390);
    step(1'b1, 18'd262143);
    step(1'b0, 18'd12345);
    step(1'b1, 18'd262140);
    for (int a = 0; a < 262144; a += 131) begin
      step(1'b1, 18'(a));
      if (a % 1048 == 0) step(1'b0, 18'(a + 7));
    end
    repeat (4) step(1'b0, 18'd0);
    chk(in_ready === 1'b1, "R7 ready stays high", in_ready, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule